// File: doc/BRIEF.md
# Debug Data Address Compare Unit

This block sits beside a processor's data-side access path and watches every load and store. It holds a small set of address compare events (two by default). An event matches an access by exact effective address, by effective address under a bit mask, or by position relative to an inclusive window whose bounds are the first two compare addresses. An event can also be limited to user or supervisor accesses, to one data-space setting and to loads or stores. It can additionally require that the transferred bytes equal a programmed value. A match never stops the access.

Hits are gathered over all accesses of one instruction and committed when the pipeline signals that the instruction has completed. The commit sets sticky status bits and saves a return address. When none of the instruction's accesses faulted, the report is precise and the saved address is the following instruction. When an access faulted, the report is imprecise and points at the load or store itself. An instruction cut short by an external or critical interrupt records nothing. The exception request stays raised while debug is enabled and any enabled event's status bit is still set. Software clears status bits by writing ones.

Top module: `dbg_dac_unit`

## Requirements
- R1: Each event e has its own status bit e. In mode 0 it matches when the access address equals the event's compare address. In mode 1 it matches when the address agrees with the compare address in every bit where the event's mask holds a one.
- R2: In mode 2 an event matches when the address lies between compare address 0 and compare address 1, both bounds included. In mode 3 it matches when the address lies outside that window.
- R3: Status bits are sticky. Writing clr_mask with clr_valid clears the bits where clr_mask is one. A commit in the same cycle wins over the clear. Hits are recorded whatever the value of dbg_en.
- R4: A commit takes place on the cycle of ins_done and covers all of the instruction's accesses, including one presented in that same cycle. The new status is visible from the following cycle. If no access of the instruction faulted, ret_addr becomes ins_next_pc and the imprecise bit (status bit NEV) is left unchanged.
- R5: If any access of a committing instruction faulted and at least one event is recorded, ret_addr becomes ins_pc and status bit NEV is set.
- R6: An access flagged as the second half of a split misaligned access never produces a hit.
- R7: With value compare enabled, an event hits only if acc_be is nonzero and every byte lane whose enable is set (lane i = bits 8i+7..8i) equals the same lane of the event's compare value. An access with value compare enabled that faults produces no hit for that event.
- R8: A value-compare hit on an earlier access of an instruction is still recorded, imprecisely, when a later access of the same instruction faults.
- R9: When ins_done arrives with ins_abort set, nothing is recorded and ret_addr is kept.
- R10: Qualifier encodings per event: privilege bit 1 allows user accesses and bit 0 allows supervisor accesses. Space bit 1 allows acc_ds=1 and bit 0 allows acc_ds=0. Kind bit 1 allows stores and bit 0 allows loads. An access matches only when all three allow it and the event is enabled.
- R11: dbg_exc is high exactly when dbg_en is high and some status bit e < NEV with cfg_en[e] set is one. It stays high until those bits are cleared.
- R12: After reset the status, ret_addr and dbg_exc are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_en | input | 1 | Global debug exception enable |
| cfg_en | input | NEV | Per-event enable |
| cfg_mode | input | 2*NEV | Per-event compare mode (0 exact, 1 masked, 2 inside, 3 outside) |
| cfg_addr | input | AW*NEV | Per-event compare address |
| cfg_mask | input | AW*NEV | Per-event address mask (1 = bit compared) |
| cfg_priv | input | 2*NEV | Privilege qualifier |
| cfg_space | input | 2*NEV | Data-space qualifier |
| cfg_kind | input | 2*NEV | Load/store qualifier |
| cfg_vc_en | input | NEV | Per-event value compare enable |
| cfg_vc_data | input | DW*NEV | Per-event compare value |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Effective address |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| acc_ds | input | 1 | Data-space state bit |
| acc_be | input | DW/8 | Byte lane enables |
| acc_data | input | DW | Data transferred |
| acc_split2 | input | 1 | Second half of a split misaligned access |
| acc_fault | input | 1 | Access took a translation or storage fault |
| ins_done | input | 1 | Instruction finished (strobe) |
| ins_abort | input | 1 | Instruction cut short by an interrupt |
| ins_pc | input | AW | Address of the finishing instruction |
| ins_next_pc | input | AW | Address of the next instruction |
| clr_valid | input | 1 | Status clear write |
| clr_mask | input | NEV+1 | Write-one-to-clear mask |
| dac_status | output | NEV+1 | Hit bits, plus the imprecise bit at NEV |
| dbg_exc | output | 1 | Debug exception request |
| ret_addr | output | AW | Saved return address |

## Verification
A wrong compare or qualifier term shows in the status word one cycle after the instruction completes, as a missing or extra hit bit. Sweeps over all modes, qualifier codes and byte enables expose it against an arithmetic model. A pending hit or fault flag that is not cleared between instructions shows one instruction later, as a spurious bit or a wrong saved address. A broken clear path or exception term shows at dbg_exc in the cycle after the write.

// File: rtl/dac_pkg.sv
`timescale 1ns/1ps
// Shared types for the data address compare unit.
package dac_pkg;
    // Compare mode selected per event.
    typedef enum logic [1:0] {
        CMP_EXACT   = 2'd0,
        CMP_MASKED  = 2'd1,
        CMP_INSIDE  = 2'd2,
        CMP_OUTSIDE = 2'd3
    } cmp_mode_e;
endpackage

// File: rtl/dac_addr_match.sv
`timescale 1ns/1ps
// Address and qualifier match for one compare event.
// Assumes range bounds are supplied by the parent (low <= high for a
// meaningful window). Purely combinational.
module dac_addr_match
    import dac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_write,
    input  logic          acc_user,
    input  logic          acc_ds,
    input  logic [AW-1:0] cmp_addr,
    input  logic [AW-1:0] cmp_mask,
    input  logic [AW-1:0] range_lo,
    input  logic [AW-1:0] range_hi,
    input  logic [1:0]    mode,
    input  logic [1:0]    priv,
    input  logic [1:0]    space,
    input  logic [1:0]    kind,
    output logic          match
);
    logic in_window;
    logic addr_ok;
    logic qual_ok;

    // Window test shared by the inside and outside modes.
    assign in_window = (acc_addr >= range_lo) && (acc_addr <= range_hi);

    // Address test chosen by the event's mode.
    always_comb begin
        unique case (cmp_mode_e'(mode))
            CMP_EXACT:   addr_ok = (acc_addr == cmp_addr);
            CMP_MASKED:  addr_ok = ((acc_addr ^ cmp_addr) & cmp_mask) == '0;
            CMP_INSIDE:  addr_ok = in_window;
            default:     addr_ok = !in_window;
        endcase
    end

    // Privilege, data-space and access-kind qualification.
    assign qual_ok = priv[acc_user] & space[acc_ds] & kind[acc_write];

    assign match = addr_ok & qual_ok;
endmodule

// File: rtl/dac_value_match.sv
`timescale 1ns/1ps
// Byte-lane data value compare for one event.
// Assumes DW is a multiple of 8. Matches only when at least one lane is
// enabled and all enabled lanes are equal to the reference value.
module dac_value_match #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   acc_data,
    input  logic [DW/8-1:0] acc_be,
    input  logic [DW-1:0]   ref_data,
    output logic            match
);
    localparam int BW = DW / 8;

    logic [BW-1:0] lane_ok;

    // Per-lane equality, ignored where the lane is not enabled.
    for (genvar i = 0; i < BW; i++) begin : g_lane
        assign lane_ok[i] = !acc_be[i] || (acc_data[8*i +: 8] == ref_data[8*i +: 8]);
    end

    assign match = (&lane_ok) && (|acc_be);
endmodule

// File: rtl/dac_report.sv
`timescale 1ns/1ps
// Per-instruction hit collection, sticky status and exception report.
// Assumes ins_done is a one-cycle strobe per instruction and that an access
// in the same cycle as ins_done belongs to the finishing instruction.
module dac_report #(
    parameter int NEV = 2,
    parameter int AW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dbg_en,
    input  logic [NEV-1:0] ev_en,
    input  logic           acc_valid,
    input  logic           acc_fault,
    input  logic [NEV-1:0] acc_hit,
    input  logic           ins_done,
    input  logic           ins_abort,
    input  logic [AW-1:0]  ins_pc,
    input  logic [AW-1:0]  ins_next_pc,
    input  logic           clr_valid,
    input  logic [NEV:0]   clr_mask,
    output logic [NEV:0]   status,
    output logic [AW-1:0]  ret_addr,
    output logic           exc
);
    localparam int IMP = NEV;

    logic [NEV-1:0] pend_q;
    logic           fault_q;
    logic [NEV-1:0] all_hits;
    logic           all_fault;
    logic           commit;
    logic [NEV:0]   status_kept;

    // Merge this cycle's access into the running instruction state.
    assign all_hits  = pend_q | (acc_valid ? acc_hit : '0);
    assign all_fault = fault_q | (acc_valid & acc_fault);
    assign commit    = ins_done && !ins_abort && (|all_hits);
    assign status_kept = clr_valid ? (status & ~clr_mask) : status;

    // Accumulate hits and faults until the instruction finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            fault_q <= 1'b0;
        end else if (ins_done) begin
            pend_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            pend_q  <= all_hits;
            fault_q <= all_fault;
        end
    end

    // Sticky status with write-one-to-clear; a commit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (commit) begin
            status <= status_kept | {all_fault, all_hits};
        end else begin
            status <= status_kept;
        end
    end

    // Saved return address, chosen by precise or imprecise reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr <= '0;
        end else if (commit) begin
            ret_addr <= all_fault ? ins_pc : ins_next_pc;
        end
    end

    // Exception request from enabled sticky hits.
    assign exc = dbg_en && (|(status[NEV-1:0] & ev_en));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_valid |=> ((status & $past(status)) == $past(status)));

    p_precise_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done && !ins_abort && (|all_hits) && !all_fault)
        |=> (ret_addr == $past(ins_next_pc)));

    p_imprecise_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done && !ins_abort && (|all_hits) && all_fault)
        |=> (ret_addr == $past(ins_pc)) && status[IMP]);

    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done && ins_abort && !clr_valid) |=> ($stable(status) && $stable(ret_addr)));

    p_exc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc && !clr_valid) |=> (exc || !dbg_en || !$stable(ev_en)));
endmodule

// File: rtl/dbg_dac_unit.sv
`timescale 1ns/1ps
// Debug data address compare unit, top level.
// Instantiates one address matcher and one value matcher per event and a
// shared report stage. Assumes NEV >= 2: the window bounds are the compare
// addresses of events 0 and 1. Synchronous active-low reset.
module dbg_dac_unit #(
    parameter int NEV = 2,
    parameter int AW  = 32,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic [NEV-1:0]    cfg_en,
    input  logic [2*NEV-1:0]  cfg_mode,
    input  logic [AW*NEV-1:0] cfg_addr,
    input  logic [AW*NEV-1:0] cfg_mask,
    input  logic [2*NEV-1:0]  cfg_priv,
    input  logic [2*NEV-1:0]  cfg_space,
    input  logic [2*NEV-1:0]  cfg_kind,
    input  logic [NEV-1:0]    cfg_vc_en,
    input  logic [DW*NEV-1:0] cfg_vc_data,
    input  logic              acc_valid,
    input  logic [AW-1:0]     acc_addr,
    input  logic              acc_write,
    input  logic              acc_user,
    input  logic              acc_ds,
    input  logic [DW/8-1:0]   acc_be,
    input  logic [DW-1:0]     acc_data,
    input  logic              acc_split2,
    input  logic              acc_fault,
    input  logic              ins_done,
    input  logic              ins_abort,
    input  logic [AW-1:0]     ins_pc,
    input  logic [AW-1:0]     ins_next_pc,
    input  logic              clr_valid,
    input  logic [NEV:0]      clr_mask,
    output logic [NEV:0]      dac_status,
    output logic              dbg_exc,
    output logic [AW-1:0]     ret_addr
);
    localparam int LO_EV = 0;
    localparam int HI_EV = 1;

    logic [AW-1:0]  win_lo;
    logic [AW-1:0]  win_hi;
    logic [NEV-1:0] addr_ok;
    logic [NEV-1:0] value_ok;
    logic [NEV-1:0] ev_hit;

    assign win_lo = cfg_addr[LO_EV*AW +: AW];
    assign win_hi = cfg_addr[HI_EV*AW +: AW];

    for (genvar e = 0; e < NEV; e++) begin : g_event
        dac_addr_match #(.AW(AW)) u_addr (
            .acc_addr  (acc_addr),
            .acc_write (acc_write),
            .acc_user  (acc_user),
            .acc_ds    (acc_ds),
            .cmp_addr  (cfg_addr[e*AW +: AW]),
            .cmp_mask  (cfg_mask[e*AW +: AW]),
            .range_lo  (win_lo),
            .range_hi  (win_hi),
            .mode      (cfg_mode[2*e +: 2]),
            .priv      (cfg_priv[2*e +: 2]),
            .space     (cfg_space[2*e +: 2]),
            .kind      (cfg_kind[2*e +: 2]),
            .match     (addr_ok[e])
        );

        dac_value_match #(.DW(DW)) u_value (
            .acc_data (acc_data),
            .acc_be   (acc_be),
            .ref_data (cfg_vc_data[e*DW +: DW]),
            .match    (value_ok[e])
        );

        // Event hit: split halves never count; a value-gated event needs
        // completed data, so a faulted access cannot hit it.
        assign ev_hit[e] = cfg_en[e] && addr_ok[e] && !acc_split2 &&
                           (!cfg_vc_en[e] || (value_ok[e] && !acc_fault));
    end

    dac_report #(.NEV(NEV), .AW(AW)) u_report (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_en      (dbg_en),
        .ev_en       (cfg_en),
        .acc_valid   (acc_valid),
        .acc_fault   (acc_fault),
        .acc_hit     (ev_hit),
        .ins_done    (ins_done),
        .ins_abort   (ins_abort),
        .ins_pc      (ins_pc),
        .ins_next_pc (ins_next_pc),
        .clr_valid   (clr_valid),
        .clr_mask    (clr_mask),
        .status      (dac_status),
        .ret_addr    (ret_addr),
        .exc         (dbg_exc)
    );

    p_split_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done && !ins_abort && acc_valid && acc_split2 && !clr_valid)
        |=> (dac_status[NEV-1:0] == $past(dac_status[NEV-1:0]))
            || ($past(dac_status[NEV-1:0]) != '0) || 1'b1 == $past(acc_valid && !acc_split2));
endmodule

// File: tb/dbg_dac_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_dac_unit_tb_top;
    localparam int NEV = 2;
    localparam int AW  = 32;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dbg_en = 1'b0;
    logic [NEV-1:0]    cfg_en = '0;
    logic [2*NEV-1:0]  cfg_mode = '0;
    logic [AW*NEV-1:0] cfg_addr = '0;
    logic [AW*NEV-1:0] cfg_mask = '0;
    logic [2*NEV-1:0]  cfg_priv = '1;
    logic [2*NEV-1:0]  cfg_space = '1;
    logic [2*NEV-1:0]  cfg_kind = '1;
    logic [NEV-1:0]    cfg_vc_en = '0;
    logic [DW*NEV-1:0] cfg_vc_data = '0;
    logic              acc_valid = 1'b0;
    logic [AW-1:0]     acc_addr = '0;
    logic              acc_write = 1'b0;
    logic              acc_user = 1'b0;
    logic              acc_ds = 1'b0;
    logic [DW/8-1:0]   acc_be = '1;
    logic [DW-1:0]     acc_data = '0;
    logic              acc_split2 = 1'b0;
    logic              acc_fault = 1'b0;
    logic              ins_done = 1'b0;
    logic              ins_abort = 1'b0;
    logic [AW-1:0]     ins_pc = '0;
    logic [AW-1:0]     ins_next_pc = '0;
    logic              clr_valid = 1'b0;
    logic [NEV:0]      clr_mask = '0;
    logic [NEV:0]      dac_status;
    logic              dbg_exc;
    logic [AW-1:0]     ret_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [AW-1:0] pc_ctr = 32'h0000_4000;
    logic [AW-1:0] exp_ret = '0;

    always #4 clk = ~clk;

    dbg_dac_unit #(.NEV(NEV), .AW(AW), .DW(DW)) dut_i (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model of one event's hit, from the requirements.
    function automatic logic model_hit(input int e, input logic [31:0] a, input logic w, u, d,
                                       input logic [3:0] be, input logic [31:0] dat,
                                       input logic sp, f);
        logic [31:0] ca, mk, lo, hi, vv;
        logic aok, vok;
        ca = cfg_addr[e*32 +: 32];
        mk = cfg_mask[e*32 +: 32];
        lo = cfg_addr[31:0];
        hi = cfg_addr[63:32];
        vv = cfg_vc_data[e*32 +: 32];
        case (cfg_mode[2*e +: 2])
            2'd0: aok = (a == ca);
            2'd1: aok = ((a & mk) == (ca & mk));
            2'd2: aok = (a >= lo) && (a <= hi);
            default: aok = (a < lo) || (a > hi);
        endcase
        vok = (be != 0);
        for (int i = 0; i < 4; i++)
            if (be[i] && (dat[8*i +: 8] != vv[8*i +: 8])) vok = 1'b0;
        model_hit = cfg_en[e] && aok && !sp
                    && cfg_priv[2*e + (u ? 1 : 0)] && cfg_space[2*e + (d ? 1 : 0)]
                    && cfg_kind[2*e + (w ? 1 : 0)]
                    && (!cfg_vc_en[e] || (vok && !f));
    endfunction

    task automatic clear_all();
        @(negedge clk);
        clr_valid = 1'b1; clr_mask = '1;
        @(negedge clk);
        clr_valid = 1'b0; clr_mask = '0;
    endtask

    // One single-access instruction, then status and address checks.
    task automatic run1(input string req, input logic [31:0] a, input logic w, u, d,
                        input logic [3:0] be, input logic [31:0] dat,
                        input logic sp, f, ab);
        logic [1:0] hits;
        logic imp;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_user = u; acc_ds = d;
        acc_be = be; acc_data = dat; acc_split2 = sp; acc_fault = f;
        ins_done = 1'b1; ins_abort = ab; ins_pc = pc_ctr; ins_next_pc = pc_ctr + 4;
        for (int e = 0; e < NEV; e++) hits[e] = model_hit(e, a, w, u, d, be, dat, sp, f);
        if (ab) hits = '0;
        imp = f && (hits != 0);
        if (hits != 0) exp_ret = f ? pc_ctr : pc_ctr + 4;
        @(negedge clk);
        acc_valid = 1'b0; ins_done = 1'b0; ins_abort = 1'b0;
        acc_split2 = 1'b0; acc_fault = 1'b0;
        check(req, dac_status, {imp, hits});
        check(req, ret_addr, exp_ret);
        pc_ctr = pc_ctr + 8;
        clear_all();
    endtask

    initial begin
        logic [31:0] addrs [10];
        addrs = '{32'hFF, 32'h100, 32'h101, 32'h1F0, 32'h1FF,
                  32'h200, 32'h201, 32'h20F, 32'h210, 32'h300};
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 status", dac_status, 0);
        check("R12 ret", ret_addr, 0);
        check("R12 exc", dbg_exc, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: every mode over addresses near both bounds
        cfg_en = 2'b11;
        cfg_addr = {32'h200, 32'h100};
        cfg_mask = {32'hFFFF_FFF0, 32'hFFFF_FF00};
        for (int m = 0; m < 4; m++) begin
            cfg_mode = {m[1:0], m[1:0]};
            foreach (addrs[k])
                run1(m < 2 ? "R1 mode" : "R2 window", addrs[k], 1'b0, 1'b0, 1'b0,
                     4'hF, 32'h0, 1'b0, 1'b0, 1'b0);
        end

        // R10: all qualifier codes against all access attributes
        cfg_mode = 4'b0000; cfg_en = 2'b01;
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                for (int t = 0; t < 4; t++) begin
                    cfg_priv = {2'b11, p[1:0]};
                    cfg_space = {2'b11, s[1:0]};
                    cfg_kind = {2'b11, t[1:0]};
                    for (int v = 0; v < 8; v++)
                        run1("R10 qualifier", 32'h100, v[2], v[1], v[0],
                             4'hF, 32'h0, 1'b0, 1'b0, 1'b0);
                end
        cfg_priv = '1; cfg_space = '1; cfg_kind = '1;

        // R7: value compare over all byte enables, matching and one-lane-off data
        cfg_vc_en = 2'b01;
        cfg_vc_data = {32'h0, 32'hA1B2_C3D4};
        for (int b = 0; b < 16; b++)
            for (int k = 0; k < 5; k++)
                run1("R7 value", 32'h100, 1'b1, 1'b0, 1'b0, b[3:0],
                     (k == 4) ? 32'hA1B2_C3D4 : (32'hA1B2_C3D4 ^ (32'h1 << (8 * k))),
                     1'b0, 1'b0, 1'b0);
        run1("R7 value fault", 32'h100, 1'b1, 1'b0, 1'b0, 4'hF, 32'hA1B2_C3D4,
             1'b0, 1'b1, 1'b0);

        // R6: split second half never hits
        cfg_vc_en = 2'b00; cfg_en = 2'b11; cfg_mode = 4'b1010;
        run1("R6 split", 32'h180, 1'b0, 1'b0, 1'b0, 4'hF, 32'h0, 1'b1, 1'b0, 1'b0);
        run1("R6 split fault", 32'h180, 1'b0, 1'b0, 1'b0, 4'hF, 32'h0, 1'b1, 1'b1, 1'b0);

        // R4 / R5: precise against imprecise report
        run1("R4 precise", 32'h180, 1'b0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, 1'b0);
        run1("R5 imprecise", 32'h180, 1'b1, 1'b0, 1'b0, 4'hF, 32'h0, 1'b0, 1'b1, 1'b0);

        // R9: aborted instruction records nothing
        run1("R9 abort", 32'h180, 1'b0, 1'b0, 1'b0, 4'hF, 32'h0, 1'b0, 1'b0, 1'b1);

        // R8: earlier value hit survives a later faulting transfer
        cfg_en = 2'b01; cfg_mode = 4'b0000; cfg_vc_en = 2'b01;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h100; acc_be = 4'hF; acc_data = 32'hA1B2_C3D4;
        acc_fault = 1'b0;
        @(negedge clk);
        acc_addr = 32'h104; acc_fault = 1'b1;
        ins_done = 1'b1; ins_pc = 32'h0000_9000; ins_next_pc = 32'h0000_9004;
        @(negedge clk);
        acc_valid = 1'b0; acc_fault = 1'b0; ins_done = 1'b0;
        check("R8 multiword status", dac_status, 3'b101);
        check("R8 multiword ret", ret_addr, 32'h0000_9000);
        exp_ret = 32'h0000_9000;
        // R9: pending hits dropped on abort; ret kept
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h100; acc_data = 32'hA1B2_C3D4;
        @(negedge clk);
        acc_valid = 1'b0; ins_done = 1'b1; ins_abort = 1'b1;
        clr_valid = 1'b1; clr_mask = '1;
        @(negedge clk);
        ins_done = 1'b0; ins_abort = 1'b0; clr_valid = 1'b0; clr_mask = '0;
        check("R9 abort pending status", dac_status, 0);
        check("R9 abort pending ret", ret_addr, exp_ret);
        // R4: next instruction sees no stale pending hit
        @(negedge clk);
        ins_done = 1'b1; ins_pc = 32'h0000_9100; ins_next_pc = 32'h0000_9104;
        @(negedge clk);
        ins_done = 1'b0;
        check("R4 no stale pending", dac_status, 0);
        cfg_vc_en = 2'b00;

        // R3 / R11: recording with debug disabled, exception hold and clears
        dbg_en = 1'b0; cfg_en = 2'b01;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h100; acc_fault = 1'b0;
        ins_done = 1'b1; ins_pc = 32'h0000_A000; ins_next_pc = 32'h0000_A004;
        @(negedge clk);
        acc_valid = 1'b0; ins_done = 1'b0;
        check("R3 record with debug off", dac_status, 3'b001);
        check("R11 exc off", dbg_exc, 0);
        dbg_en = 1'b1;
        #1 check("R11 exc on", dbg_exc, 1);
        repeat (3) @(negedge clk);
        check("R11 exc held", dbg_exc, 1);
        clr_valid = 1'b1; clr_mask = 3'b010;
        @(negedge clk);
        clr_valid = 1'b0;
        check("R3 partial clear", dac_status, 3'b001);
        check("R11 exc after other clear", dbg_exc, 1);
        cfg_en = 2'b10;
        #1 check("R11 exc masked by enable", dbg_exc, 0);
        cfg_en = 2'b01;
        // R3: commit wins over a same-cycle clear
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h100; ins_done = 1'b1;
        clr_valid = 1'b1; clr_mask = '1;
        @(negedge clk);
        acc_valid = 1'b0; ins_done = 1'b0; clr_valid = 1'b0;
        check("R3 set wins", dac_status, 3'b001);
        clr_valid = 1'b1; clr_mask = 3'b001;
        @(negedge clk);
        clr_valid = 1'b0;
        check("R3 w1c", dac_status, 3'b000);
        check("R11 exc cleared", dbg_exc, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule